// File: doc/BRIEF.md
# Pointer and Stack Address Unit

This unit keeps the two 16-bit data pointers (P1, P2) and the stack pointer (SP) of a small 8-bit processor. The instruction decoder sends it one command per clock. The commands are a pointer-group operation selected by a 4-bit code, a 4-bit immediate written into one nibble of P1, a push, or a pop. The processor core supplies the two data bytes A and B. The unit returns a byte taken from P1 when the core moves a pointer half into A or B.

For push and pop, the unit produces the memory address of the stack access and a one-cycle strobe. It also keeps a pointers-equal flag. Every pointer-group operation refreshes this flag from the pointer values that result from that operation. All outputs are registered, so each result appears on the clock edge that follows the command.

Top module: `ptr_addr_unit`

## Requirements
- R1: A synchronous active-high reset clears P1, P2, SP, the pointers-equal flag, both stack strobes and both read-back strobes to zero.
- R2: With `cmd_i`=1 (pointer group), codes 0, 1, 2 and 3 add one to P1, add one to P2, subtract one from P1 and subtract one from P2. The result wraps modulo 2^16 (FFFF+1=0000, 0000-1=FFFF).
- R3: Group codes 4 to 7 copy P2 into P1, copy P1 into P2, copy SP into P1 and copy P1 into SP.
- R4: Group codes 8 to 11 place a P1 byte on `rd_byte_o` one cycle later. Code 8 gives the low byte with `rd_to_a_o`, 9 the high byte with `rd_to_a_o`, 10 the low byte with `rd_to_b_o` and 11 the high byte with `rd_to_b_o`. No pointer changes.
- R5: Group codes 12 to 15 write a byte into P1 and keep its other half. Code 12 writes A into bits 7:0, 13 writes A into bits 15:8, 14 writes B into bits 7:0 and 15 writes B into bits 15:8.
- R6: With `cmd_i`=2 (immediate), `imm_i` replaces P1 bits 3:0, 7:4, 11:8 or 15:12 for `sub_i[1:0]` = 0, 1, 2 or 3. All other P1 bits stay unchanged.
- R7: After every pointer-group command, `peq_o` is 1 exactly when P1 equals P2 as they stand after that command.
- R8: Immediate, push, pop and idle commands leave `peq_o` unchanged, even when they alter P1 or SP.
- R9: With `cmd_i`=3 (push), the next cycle shows `stk_addr_o` equal to the SP before the push and `stk_wr_o`=1, and SP has gone up by one (mod 2^16).
- R10: With `cmd_i`=4 (pop), SP goes down by one (mod 2^16), and the next cycle shows `stk_addr_o` equal to that new SP and `stk_rd_o`=1.
- R11: `cmd_i` values 0, 5, 6 and 7 change no pointer and no flag, and they raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 3 | Command: 0 idle, 1 pointer group, 2 immediate, 3 push, 4 pop |
| sub_i | input | 4 | Group code, or nibble index in bits 1:0 for immediate |
| imm_i | input | 4 | Immediate nibble |
| a_i | input | 8 | Accumulator byte |
| b_i | input | 8 | Secondary byte |
| p1_o | output | 16 | Pointer P1 |
| p2_o | output | 16 | Pointer P2 |
| sp_o | output | 16 | Stack pointer |
| peq_o | output | 1 | Pointers-equal flag |
| rd_byte_o | output | 8 | Byte read back from P1 |
| rd_to_a_o | output | 1 | Read-back byte is for A |
| rd_to_b_o | output | 1 | Read-back byte is for B |
| stk_addr_o | output | 16 | Stack access address |
| stk_wr_o | output | 1 | Stack write strobe (push) |
| stk_rd_o | output | 1 | Stack read strobe (pop) |

## Verification
The bench builds the unit with its default parameters: 16-bit pointers, byte-wide data and nibble immediates. With these values, four immediate writes reach the all-ones pointer, so the bench can check the FFFF/0000 wrap of P1, P2 and SP directly. Because a whole pointer is only four immediates or two byte writes, the bench can also set P1 and P2 equal and unequal many times and check that the equal flag stays unchanged after immediates and stack commands.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE = 3'd0,
    CMD_GRP  = 3'd1,
    CMD_IMM  = 3'd2,
    CMD_PUSH = 3'd3,
    CMD_POP  = 3'd4
  } cmd_e;

  // group code classes taken from sub[3:2]
  localparam logic [1:0] CLS_STEP = 2'd0;
  localparam logic [1:0] CLS_COPY = 2'd1;
  localparam logic [1:0] CLS_READ = 2'd2;
  localparam logic [1:0] CLS_WRIT = 2'd3;
endpackage

// File: rtl/ptr_step.sv
module ptr_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic [W-1:0] res_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    if (dec_i) res_o = val_i - ONE;
    else       res_o = val_i + ONE;
  end
endmodule

// File: rtl/ptr_lane_merge.sv
module ptr_lane_merge #(
  parameter int W  = 16,
  parameter int LW = 4
) (
  input  logic [W-1:0]  base_i,
  input  logic [((W/LW) > 1 ? $clog2(W/LW) : 1)-1:0] sel_i,
  input  logic [LW-1:0] lane_i,
  output logic [W-1:0]  res_o
);
  localparam int NL = W / LW;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    always_comb begin
      if (int'(sel_i) == g) res_o[g*LW +: LW] = lane_i;
      else                  res_o[g*LW +: LW] = base_i[g*LW +: LW];
    end
  end
endmodule

// File: rtl/ptr_stack_gen.sv
module ptr_stack_gen #(
  parameter int W = 16
) (
  input  logic [W-1:0] sp_i,
  input  logic         pop_i,
  output logic [W-1:0] sp_next_o,
  output logic [W-1:0] addr_o
);
  logic [W-1:0] moved;

  ptr_step #(.W(W)) u_step (
    .val_i (sp_i),
    .dec_i (pop_i),
    .res_o (moved)
  );

  // push uses the old SP, pop uses the decremented SP
  assign sp_next_o = moved;
  assign addr_o    = pop_i ? moved : sp_i;
endmodule

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit #(
  parameter int PW = 16,
  parameter int DW = 8,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    cmd_i,
  input  logic [3:0]    sub_i,
  input  logic [NW-1:0] imm_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [PW-1:0] p1_o,
  output logic [PW-1:0] p2_o,
  output logic [PW-1:0] sp_o,
  output logic          peq_o,
  output logic [DW-1:0] rd_byte_o,
  output logic          rd_to_a_o,
  output logic          rd_to_b_o,
  output logic [PW-1:0] stk_addr_o,
  output logic          stk_wr_o,
  output logic          stk_rd_o
);
  import ptr_pkg::*;

  localparam int NLANES = PW / NW;
  localparam int NSW    = (NLANES > 1) ? $clog2(NLANES) : 1;
  localparam int NHALF  = PW / DW;
  localparam int HSW    = (NHALF > 1) ? $clog2(NHALF) : 1;

  cmd_e cmd;
  assign cmd = cmd_e'(cmd_i);

  logic [PW-1:0] p1_q, p2_q, sp_q, stk_addr_q;
  logic          peq_q, stk_wr_q, stk_rd_q, rd_a_q, rd_b_q;
  logic [DW-1:0] rd_byte_q;

  logic [PW-1:0] p1_n, p2_n, sp_n, stk_addr_n;
  logic          peq_n, stk_wr_n, stk_rd_n, rd_a_n, rd_b_n;
  logic [DW-1:0] rd_byte_n;

  // shared step unit: sub[0] picks P2, sub[1] picks decrement
  logic [PW-1:0] step_in, step_out;
  assign step_in = sub_i[0] ? p2_q : p1_q;

  ptr_step #(.W(PW)) u_step (
    .val_i (step_in),
    .dec_i (sub_i[1]),
    .res_o (step_out)
  );

  // immediate nibble into P1
  logic [PW-1:0] p1_imm;
  ptr_lane_merge #(.W(PW), .LW(NW)) u_nib (
    .base_i (p1_q),
    .sel_i  (NSW'(sub_i[1:0])),
    .lane_i (imm_i),
    .res_o  (p1_imm)
  );

  // byte from A or B into a half of P1
  logic [PW-1:0] p1_byte;
  logic [DW-1:0] byte_src;
  assign byte_src = sub_i[1] ? b_i : a_i;

  ptr_lane_merge #(.W(PW), .LW(DW)) u_byte (
    .base_i (p1_q),
    .sel_i  (HSW'(sub_i[0])),
    .lane_i (byte_src),
    .res_o  (p1_byte)
  );

  // stack address
  logic [PW-1:0] sp_moved, stk_addr_c;
  ptr_stack_gen #(.W(PW)) u_stk (
    .sp_i      (sp_q),
    .pop_i     (cmd == CMD_POP),
    .sp_next_o (sp_moved),
    .addr_o    (stk_addr_c)
  );

  always_comb begin
    p1_n       = p1_q;
    p2_n       = p2_q;
    sp_n       = sp_q;
    peq_n      = peq_q;
    stk_addr_n = stk_addr_q;
    stk_wr_n   = 1'b0;
    stk_rd_n   = 1'b0;
    rd_a_n     = 1'b0;
    rd_b_n     = 1'b0;
    rd_byte_n  = rd_byte_q;
    case (cmd)
      CMD_GRP: begin
        case (sub_i[3:2])
          CLS_STEP: begin
            if (sub_i[0]) p2_n = step_out;
            else          p1_n = step_out;
          end
          CLS_COPY: begin
            case (sub_i[1:0])
              2'd0:    p1_n = p2_q;
              2'd1:    p2_n = p1_q;
              2'd2:    p1_n = sp_q;
              default: sp_n = p1_q;
            endcase
          end
          CLS_READ: begin
            rd_byte_n = sub_i[0] ? p1_q[PW-1 -: DW] : p1_q[DW-1:0];
            rd_a_n    = ~sub_i[1];
            rd_b_n    = sub_i[1];
          end
          default: p1_n = p1_byte;
        endcase
        peq_n = (p1_n == p2_n);
      end
      CMD_IMM: p1_n = p1_imm;
      CMD_PUSH: begin
        sp_n       = sp_moved;
        stk_addr_n = stk_addr_c;
        stk_wr_n   = 1'b1;
      end
      CMD_POP: begin
        sp_n       = sp_moved;
        stk_addr_n = stk_addr_c;
        stk_rd_n   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_q       <= '0;
      p2_q       <= '0;
      sp_q       <= '0;
      peq_q      <= 1'b0;
      stk_addr_q <= '0;
      stk_wr_q   <= 1'b0;
      stk_rd_q   <= 1'b0;
      rd_a_q     <= 1'b0;
      rd_b_q     <= 1'b0;
      rd_byte_q  <= '0;
    end else begin
      p1_q       <= p1_n;
      p2_q       <= p2_n;
      sp_q       <= sp_n;
      peq_q      <= peq_n;
      stk_addr_q <= stk_addr_n;
      stk_wr_q   <= stk_wr_n;
      stk_rd_q   <= stk_rd_n;
      rd_a_q     <= rd_a_n;
      rd_b_q     <= rd_b_n;
      rd_byte_q  <= rd_byte_n;
    end
  end

  assign p1_o       = p1_q;
  assign p2_o       = p2_q;
  assign sp_o       = sp_q;
  assign peq_o      = peq_q;
  assign stk_addr_o = stk_addr_q;
  assign stk_wr_o   = stk_wr_q;
  assign stk_rd_o   = stk_rd_q;
  assign rd_to_a_o  = rd_a_q;
  assign rd_to_b_o  = rd_b_q;
  assign rd_byte_o  = rd_byte_q;

  // ---------------- assertions ----------------
  p_peq_match_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_GRP) |=> (peq_o == (p1_o == p2_o)));

  p_peq_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_GRP) |=> $stable(peq_o));

  p_push_addr_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PUSH) |=> (stk_wr_o && stk_addr_o == $past(sp_o)
                           && sp_o == $past(sp_o) + PW'(1)));

  p_pop_addr_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_POP) |=> (stk_rd_o && stk_addr_o == sp_o
                          && sp_o == $past(sp_o) - PW'(1)));

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(stk_wr_o && stk_rd_o));

  p_rd_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_to_a_o, rd_to_b_o}));

  p_imm_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_IMM) |=> ($stable(p2_o) && $stable(sp_o)));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == 3'd0 || cmd_i > 3'd4) |=>
      ($stable(p1_o) && $stable(p2_o) && $stable(sp_o) && !stk_wr_o && !stk_rd_o));
endmodule

// File: tb/sim_ptr_addr_unit.sv
module sim_ptr_addr_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] p1, p2, sp, addr;
    logic        peq, wr, rd, ra, rb;
    logic [7:0]  rbyte;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd_i = 3'd0;
  logic [3:0]  sub_i = 4'd0;
  logic [3:0]  imm_i = 4'd0;
  logic [7:0]  a_i = 8'd0, b_i = 8'd0;
  logic [15:0] p1_o, p2_o, sp_o, stk_addr_o;
  logic        peq_o, rd_to_a_o, rd_to_b_o, stk_wr_o, stk_rd_o;
  logic [7:0]  rd_byte_o;

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  logic [15:0] m1 = 16'h0, m2 = 16'h0, ms = 16'h0;
  logic        mpeq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_addr_unit u0 (
    .clk(clk), .rst(rst), .cmd_i(cmd_i), .sub_i(sub_i), .imm_i(imm_i),
    .a_i(a_i), .b_i(b_i), .p1_o(p1_o), .p2_o(p2_o), .sp_o(sp_o),
    .peq_o(peq_o), .rd_byte_o(rd_byte_o), .rd_to_a_o(rd_to_a_o),
    .rd_to_b_o(rd_to_b_o), .stk_addr_o(stk_addr_o), .stk_wr_o(stk_wr_o),
    .stk_rd_o(stk_rd_o)
  );

  // driver: apply one command and push the expected result
  task automatic issue(input logic [2:0] c, input logic [3:0] s,
                       input logic [3:0] n, input logic [7:0] a,
                       input logic [7:0] b, input string req);
    exp_t e;
    @(negedge clk);
    cmd_i = c; sub_i = s; imm_i = n; a_i = a; b_i = b;
    e.wr = 0; e.rd = 0; e.ra = 0; e.rb = 0; e.rbyte = 0; e.addr = 0;
    e.req = req;
    case (c)
      3'd1: begin
        case (s)
          4'd0: m1 = m1 + 16'd1;
          4'd1: m2 = m2 + 16'd1;
          4'd2: m1 = m1 - 16'd1;
          4'd3: m2 = m2 - 16'd1;
          4'd4: m1 = m2;
          4'd5: m2 = m1;
          4'd6: m1 = ms;
          4'd7: ms = m1;
          4'd8:  begin e.ra = 1; e.rbyte = m1[7:0];  end
          4'd9:  begin e.ra = 1; e.rbyte = m1[15:8]; end
          4'd10: begin e.rb = 1; e.rbyte = m1[7:0];  end
          4'd11: begin e.rb = 1; e.rbyte = m1[15:8]; end
          4'd12: m1[7:0]  = a;
          4'd13: m1[15:8] = a;
          4'd14: m1[7:0]  = b;
          default: m1[15:8] = b;
        endcase
        mpeq = (m1 == m2);
      end
      3'd2: m1[s[1:0]*4 +: 4] = n;
      3'd3: begin e.addr = ms; e.wr = 1; ms = ms + 16'd1; end
      3'd4: begin ms = ms - 16'd1; e.addr = ms; e.rd = 1; end
      default: ;
    endcase
    e.p1 = m1; e.p2 = m2; e.sp = ms; e.peq = mpeq;
    q.push_back(e);
  endtask

  // monitor: compare one item per cycle, away from the edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        logic bad;
        e = q.pop_front();
        bad = (p1_o !== e.p1) || (p2_o !== e.p2) || (sp_o !== e.sp) ||
              (peq_o !== e.peq) || (stk_wr_o !== e.wr) || (stk_rd_o !== e.rd) ||
              (rd_to_a_o !== e.ra) || (rd_to_b_o !== e.rb) ||
              ((e.wr || e.rd) && stk_addr_o !== e.addr) ||
              ((e.ra || e.rb) && rd_byte_o !== e.rbyte);
        checks++;
        if (bad) begin
          errors++;
          $display("FAIL %s: got p1=%h p2=%h sp=%h peq=%b wr=%b rd=%b addr=%h ra=%b rb=%b byte=%h / exp p1=%h p2=%h sp=%h peq=%b wr=%b rd=%b addr=%h ra=%b rb=%b byte=%h",
                   e.req, p1_o, p2_o, sp_o, peq_o, stk_wr_o, stk_rd_o, stk_addr_o,
                   rd_to_a_o, rd_to_b_o, rd_byte_o, e.p1, e.p2, e.sp, e.peq,
                   e.wr, e.rd, e.addr, e.ra, e.rb, e.rbyte);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got no end / exp end of sequence");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({p1_o, p2_o, sp_o, peq_o, stk_wr_o, stk_rd_o, rd_to_a_o, rd_to_b_o} !== '0) begin
      errors++;
      $display("FAIL R1: got p1=%h p2=%h sp=%h peq=%b wr=%b rd=%b ra=%b rb=%b / exp all zero",
               p1_o, p2_o, sp_o, peq_o, stk_wr_o, stk_rd_o, rd_to_a_o, rd_to_b_o);
    end
    @(negedge clk); rst = 1'b0;

    // R6 nibble loads, R8 flag held across immediates
    issue(3'd2, 4'd0, 4'h4, 8'h00, 8'h00, "R6 nib0");
    issue(3'd2, 4'd1, 4'h3, 8'h00, 8'h00, "R6 nib1");
    issue(3'd2, 4'd2, 4'h2, 8'h00, 8'h00, "R6 nib2");
    issue(3'd2, 4'd3, 4'h1, 8'h00, 8'h00, "R6 nib3 R8");
    // R3 copy, R7 flag refresh, R2 step
    issue(3'd1, 4'd5, 4'h0, 8'h00, 8'h00, "R3 p1->p2 R7");
    issue(3'd1, 4'd0, 4'h0, 8'h00, 8'h00, "R2 inc p1 R7");
    issue(3'd1, 4'd2, 4'h0, 8'h00, 8'h00, "R2 dec p1 R7");
    issue(3'd2, 4'd0, 4'hF, 8'h00, 8'h00, "R8 imm keeps peq");
    // R4 read-back
    issue(3'd1, 4'd8,  4'h0, 8'h00, 8'h00, "R4 lo->A");
    issue(3'd1, 4'd9,  4'h0, 8'h00, 8'h00, "R4 hi->A");
    issue(3'd1, 4'd10, 4'h0, 8'h00, 8'h00, "R4 lo->B");
    issue(3'd1, 4'd11, 4'h0, 8'h00, 8'h00, "R4 hi->B");
    // R5 byte writes
    issue(3'd1, 4'd12, 4'h0, 8'hA5, 8'h3C, "R5 A->lo");
    issue(3'd1, 4'd13, 4'h0, 8'h5A, 8'h3C, "R5 A->hi");
    issue(3'd1, 4'd14, 4'h0, 8'h77, 8'h00, "R5 B->lo");
    issue(3'd1, 4'd15, 4'h0, 8'h77, 8'hFF, "R5 B->hi");
    // R3 SP copies
    issue(3'd1, 4'd7, 4'h0, 8'h00, 8'h00, "R3 p1->sp");
    issue(3'd2, 4'd0, 4'h1, 8'h00, 8'h00, "R6 nib0 set");
    issue(3'd1, 4'd6, 4'h0, 8'h00, 8'h00, "R3 sp->p1");
    issue(3'd1, 4'd4, 4'h0, 8'h00, 8'h00, "R3 p2->p1 R7");
    // R2 wrap
    for (int i = 0; i < 4; i++) issue(3'd2, 4'(i), 4'hF, 8'h00, 8'h00, "R6 all ones R8");
    issue(3'd1, 4'd0, 4'h0, 8'h00, 8'h00, "R2 p1 wrap up");
    issue(3'd1, 4'd2, 4'h0, 8'h00, 8'h00, "R2 p1 wrap down");
    issue(3'd1, 4'd3, 4'h0, 8'h00, 8'h00, "R2 dec p2");
    issue(3'd1, 4'd1, 4'h0, 8'h00, 8'h00, "R2 inc p2");
    issue(3'd1, 4'd5, 4'h0, 8'h00, 8'h00, "R3 p1->p2 R7");
    issue(3'd1, 4'd1, 4'h0, 8'h00, 8'h00, "R2 p2 wrap up");
    // R9 / R10 stack
    issue(3'd3, 4'd0, 4'h0, 8'h00, 8'h00, "R9 push");
    issue(3'd3, 4'd0, 4'h0, 8'h00, 8'h00, "R9 push again");
    issue(3'd4, 4'd0, 4'h0, 8'h00, 8'h00, "R10 pop R8");
    issue(3'd4, 4'd0, 4'h0, 8'h00, 8'h00, "R10 pop again");
    for (int i = 0; i < 4; i++) issue(3'd2, 4'(i), 4'h0, 8'h00, 8'h00, "R6 zero");
    issue(3'd1, 4'd7, 4'h0, 8'h00, 8'h00, "R3 p1->sp zero");
    issue(3'd4, 4'd0, 4'h0, 8'h00, 8'h00, "R10 pop wrap");
    issue(3'd3, 4'd0, 4'h0, 8'h00, 8'h00, "R9 push wrap");
    // R11 idle and unused commands
    issue(3'd0, 4'd7, 4'hA, 8'h12, 8'h34, "R11 idle");
    issue(3'd5, 4'd0, 4'hA, 8'h12, 8'h34, "R11 cmd5");
    issue(3'd6, 4'd5, 4'hA, 8'h12, 8'h34, "R11 cmd6");
    issue(3'd7, 4'd13, 4'hA, 8'h12, 8'h34, "R11 cmd7");
    @(negedge clk); cmd_i = 3'd0;
    repeat (3) @(posedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule